// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block lets boot software bring SDRAM devices out of power-up one command at a time. A three-bit operation mode input picks what a host access means. With the mode at zero the access is handed unchanged to a normal-access port for the data path. With any other mode the access is consumed by the block. The block then drives exactly one SDRAM command on the chip-select, RAS#, CAS#, WE# and address pins. That command is a NOP, a precharge of all banks, an auto refresh or a load of the mode register. Software walks the power-up sequence by changing the mode and issuing dummy accesses.

A power-up timer counts a programmable number of clock cycles from reset release. It raises a sticky flag when the supply-settling wait is over. A sequence tracker watches the commands that are issued and raises a sticky status flag once the legal order has been completed. That order is a NOP, then a precharge-all after the wait, then at least two auto refreshes, then a mode register load. The mode register word is constant except for one bit of CAS latency, which selects 2 or 3 cycles.

The core is the access state machine, with states ST_IDLE, ST_ISSUE, ST_RECOVER and ST_PASS. ST_IDLE accepts a pending request. It goes to ST_PASS when the mode is zero and to ST_ISSUE otherwise. ST_ISSUE drives the command for one cycle and always moves to ST_RECOVER. ST_RECOVER holds the pins deselected for REC_CYC cycles and acknowledges in its last cycle, then returns to ST_IDLE. ST_PASS pulses the normal-access request together with the acknowledge and returns to ST_IDLE.

The tracker has states TR_START, TR_NOPSEEN, TR_PRECHARGED, TR_REF_ONE, TR_REF_TWO and TR_DONE. A NOP moves TR_START to TR_NOPSEEN and leaves every other state where it is. A precharge-all moves TR_NOPSEEN to TR_PRECHARGED, and a repeated precharge keeps it in TR_PRECHARGED. A refresh steps TR_PRECHARGED to TR_REF_ONE, then to TR_REF_TWO, and further refreshes keep it in TR_REF_TWO. A mode load moves TR_REF_TWO to TR_DONE. Any other command that is not a NOP returns the tracker to TR_START. So does any command that is not a NOP while the wait is still running.

Top module: `sdram_init_cmdgen`

## Requirements
- R1: While reset is held and after its release, all chip selects, RAS#, CAS# and WE# are high and the address is zero. host_ack, norm_req, delay_done and init_ok are all low.
- R2: A request accepted with a non-zero mode drives one command for exactly one cycle, starting one cycle after acceptance, with all four chip selects low. Then the pins are deselected for REC_CYC cycles, and host_ack is high in the last of those cycles.
- R3: Mode 3'b001 produces a NOP, with pins (CS#,RAS#,CAS#,WE#) = 0111 and the address zero. The unused codes 3'b101, 3'b110 and 3'b111 produce the same NOP.
- R4: Mode 3'b010 produces a precharge-all, with pins 0010, address bit 10 high and every other address bit low.
- R5: Mode 3'b100 produces an auto refresh, with pins 0001 and the address zero.
- R6: Mode 3'b011 produces a mode register load, with pins 0000. The address carries the mode word: bits 2:0 = 010, bit 3 = 1, bits 6:4 = 010 (cas_lat3=0) or 011 (cas_lat3=1), bits 8:7 = 00, bit 9 = 1 and bits 12:10 = 0. The word is therefore 13'h022A or 13'h023A.
- R7: Mode 3'b000 issues no command. One cycle after acceptance, norm_req and host_ack are high for one cycle, with norm_we and norm_addr equal to the request's values.
- R8: delay_done goes high exactly DELAY_CYC clock edges after reset release and stays high.
- R9: init_ok goes high after this order: a NOP, then a precharge-all after delay_done, then two or more refreshes, then a mode register load. It stays high through later NOPs and normal accesses.
- R10: init_ok stays low or drops when a command that is not a NOP is out of order: a refresh or load after completion, a load after only one refresh, or a precharge before delay_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 3 | Operation mode select (000 normal, 001 NOP, 010 precharge-all, 011 mode load, 100 refresh) |
| cas_lat3 | input | 1 | CAS latency select: 0 = 2 cycles, 1 = 3 cycles |
| host_req | input | 1 | Host access request, held until host_ack |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HADDR_W | Host access address |
| host_ack | output | 1 | Access completed, one-cycle pulse |
| norm_req | output | 1 | Normal-access request to the data path |
| norm_we | output | 1 | Normal-access write flag |
| norm_addr | output | HADDR_W | Normal-access address |
| sd_cs_n | output | CS_N | SDRAM chip selects, active low |
| sd_ras_n | output | 1 | SDRAM RAS#, active low |
| sd_cas_n | output | 1 | SDRAM CAS#, active low |
| sd_we_n | output | 1 | SDRAM WE#, active low |
| sd_addr | output | 13 | SDRAM address bus |
| delay_done | output | 1 | Power-up wait elapsed (sticky) |
| init_ok | output | 1 | Power-up order completed (sticky until a fault) |

## Verification
The properties assume the host holds host_req high, with op_mode, cas_lat3, host_we and host_addr steady, from the request until the cycle host_ack is seen. They also assume the host drops host_req right after that cycle. The stimulus meets this by setting every input at a falling clock edge. Each task raises one request, follows the access until the acknowledge, and then releases host_req at that same falling edge. The tasks never overlap requests, so each access completes before the next request is raised.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int SD_AW    = 13;
    localparam int A10_BIT  = 10;
    localparam int OPM_W    = 3;

    localparam logic [OPM_W-1:0] OPM_NORMAL    = 3'b000;
    localparam logic [OPM_W-1:0] OPM_NOP       = 3'b001;
    localparam logic [OPM_W-1:0] OPM_PRECHARGE = 3'b010;
    localparam logic [OPM_W-1:0] OPM_LOADMODE  = 3'b011;
    localparam logic [OPM_W-1:0] OPM_REFRESH   = 3'b100;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } cmd_kind_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PINS_DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic cmd_kind_e decode_op(input logic [OPM_W-1:0] op);
        cmd_kind_e k;
        unique case (op)
            OPM_PRECHARGE: k = CMD_PRE;
            OPM_LOADMODE:  k = CMD_LMR;
            OPM_REFRESH:   k = CMD_REF;
            default:       k = CMD_NOP;
        endcase
        return k;
    endfunction

    function automatic pin_cmd_t pins_for(input cmd_kind_e k);
        pin_cmd_t p;
        unique case (k)
            CMD_NOP: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LMR: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
        endcase
        return p;
    endfunction

    function automatic logic [SD_AW-1:0] mode_word(input logic cl3);
        logic [SD_AW-1:0] w;
        w         = '0;
        w[2:0]    = 3'b010;
        w[3]      = 1'b1;
        w[6:4]    = cl3 ? 3'b011 : 3'b010;
        w[8:7]    = 2'b00;
        w[9]      = 1'b1;
        w[12:10]  = 3'b000;
        return w;
    endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
    parameter int DELAY_CYC = 3334
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (count_q != LIMIT) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        done = (count_q == LIMIT);
    end

endmodule

// File: rtl/sdram_access_fsm.sv
module sdram_access_fsm
    import sdram_init_pkg::*;
#(
    parameter int HADDR_W = 24,
    parameter int REC_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPM_W-1:0]   op_mode,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    output logic               host_ack,
    output logic               norm_req,
    output logic               norm_we,
    output logic [HADDR_W-1:0] norm_addr,
    output logic               cmd_fire,
    output cmd_kind_e          cmd_kind
);
    localparam int RW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
    localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RECOVER,
        ST_PASS
    } acc_state_e;

    acc_state_e         state_q, state_d;
    logic [RW-1:0]      rec_q;
    cmd_kind_e          kind_q;
    logic               we_q;
    logic [HADDR_W-1:0] addr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    state_d = (op_mode == OPM_NORMAL) ? ST_PASS : ST_ISSUE;
                end
            end
            ST_ISSUE:   state_d = ST_RECOVER;
            ST_RECOVER: begin
                if (rec_q == REC_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PASS:    state_d = ST_IDLE;
        endcase
    end

    // captured request and recovery counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q  <= '0;
            kind_q <= CMD_NOP;
            we_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && host_req) begin
                kind_q <= decode_op(op_mode);
                we_q   <= host_we;
                addr_q <= host_addr;
            end
            if (state_q == ST_RECOVER) begin
                rec_q <= rec_q + 1'b1;
            end else begin
                rec_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        host_ack  = 1'b0;
        norm_req  = 1'b0;
        cmd_fire  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ISSUE:   cmd_fire = 1'b1;
            ST_RECOVER: host_ack = (rec_q == REC_LAST);
            ST_PASS: begin
                norm_req = 1'b1;
                host_ack = 1'b1;
            end
        endcase
        cmd_kind  = kind_q;
        norm_we   = we_q & norm_req;
        norm_addr = norm_req ? addr_q : '0;
    end

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int CS_N = 4
) (
    input  logic             cmd_fire,
    input  cmd_kind_e        cmd_kind,
    input  logic             cas_lat3,
    output logic [CS_N-1:0]  sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [SD_AW-1:0] sd_addr
);
    pin_cmd_t pins;

    always_comb begin
        pins    = PINS_DESELECT;
        sd_addr = '0;
        if (cmd_fire) begin
            pins = pins_for(cmd_kind);
            unique case (cmd_kind)
                CMD_PRE: sd_addr[A10_BIT] = 1'b1;
                CMD_LMR: sd_addr = mode_word(cas_lat3);
                CMD_NOP, CMD_REF: ;
            endcase
        end
    end

    // every chip select follows the same command
    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign sd_cs_n[g] = pins.cs_n;
    end

    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

endmodule

// File: rtl/sdram_init_tracker.sv
module sdram_init_tracker
    import sdram_init_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_fire,
    input  cmd_kind_e cmd_kind,
    input  logic      delay_done,
    output logic      init_ok
);
    typedef enum logic [2:0] {
        TR_START,
        TR_NOPSEEN,
        TR_PRECHARGED,
        TR_REF_ONE,
        TR_REF_TWO,
        TR_DONE
    } trk_state_e;

    trk_state_e tr_q, tr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_q <= TR_START;
        end else begin
            tr_q <= tr_d;
        end
    end

    always_comb begin
        tr_d = tr_q;
        if (cmd_fire) begin
            if (cmd_kind == CMD_NOP) begin
                tr_d = (tr_q == TR_START) ? TR_NOPSEEN : tr_q;
            end else if (!delay_done) begin
                tr_d = TR_START;
            end else begin
                unique case (tr_q)
                    TR_START:      tr_d = TR_START;
                    TR_NOPSEEN:    tr_d = (cmd_kind == CMD_PRE) ? TR_PRECHARGED : TR_START;
                    TR_PRECHARGED: begin
                        if (cmd_kind == CMD_REF)      tr_d = TR_REF_ONE;
                        else if (cmd_kind == CMD_PRE) tr_d = TR_PRECHARGED;
                        else                          tr_d = TR_START;
                    end
                    TR_REF_ONE:    tr_d = (cmd_kind == CMD_REF) ? TR_REF_TWO : TR_START;
                    TR_REF_TWO: begin
                        if (cmd_kind == CMD_REF)      tr_d = TR_REF_TWO;
                        else if (cmd_kind == CMD_LMR) tr_d = TR_DONE;
                        else                          tr_d = TR_START;
                    end
                    TR_DONE:       tr_d = TR_START;
                    default:       tr_d = TR_START;
                endcase
            end
        end
    end

    always_comb begin
        init_ok = (tr_q == TR_DONE);
    end

endmodule

// File: rtl/sdram_init_cmdgen.sv
module sdram_init_cmdgen
    import sdram_init_pkg::*;
#(
    parameter int HADDR_W   = 24,
    parameter int CS_N      = 4,
    parameter int REC_CYC   = 3,
    parameter int DELAY_CYC = 3334
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_mode,
    input  logic               cas_lat3,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    output logic               host_ack,
    output logic               norm_req,
    output logic               norm_we,
    output logic [HADDR_W-1:0] norm_addr,
    output logic [CS_N-1:0]    sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [12:0]        sd_addr,
    output logic               delay_done,
    output logic               init_ok
);
    logic      cmd_fire;
    cmd_kind_e cmd_kind;

    sdram_pwrup_timer #(
        .DELAY_CYC (DELAY_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (delay_done)
    );

    sdram_access_fsm #(
        .HADDR_W (HADDR_W),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_mode   (op_mode),
        .host_req  (host_req),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_ack  (host_ack),
        .norm_req  (norm_req),
        .norm_we   (norm_we),
        .norm_addr (norm_addr),
        .cmd_fire  (cmd_fire),
        .cmd_kind  (cmd_kind)
    );

    sdram_cmd_drive #(
        .CS_N (CS_N)
    ) u_drive (
        .cmd_fire (cmd_fire),
        .cmd_kind (cmd_kind),
        .cas_lat3 (cas_lat3),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_addr  (sd_addr)
    );

    sdram_init_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd_kind   (cmd_kind),
        .delay_done (delay_done),
        .init_ok    (init_ok)
    );

endmodule

// File: rtl/sdram_init_cmdgen_chk.sv
module sdram_init_cmdgen_chk #(
    parameter int CS_N = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            norm_req,
    input logic [CS_N-1:0] sd_cs_n,
    input logic            sd_ras_n,
    input logic            sd_cas_n,
    input logic            sd_we_n,
    input logic [12:0]     sd_addr,
    input logic            delay_done,
    input logic            init_ok
);
    logic sel_all, sel_none, is_pre, is_lmr;

    always_comb begin
        sel_all  = (sd_cs_n == '0);
        sel_none = (sd_cs_n == '1);
        is_pre   = sel_all && !sd_ras_n && sd_cas_n && !sd_we_n;
        is_lmr   = sel_all && !sd_ras_n && !sd_cas_n && !sd_we_n;
    end

    AST_CS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        sel_all || sel_none); // R2
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_all |=> sel_none); // R2
    AST_PRE_A10_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[10]); // R4
    AST_LMR_WORD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |-> (!sd_addr[12] && sd_addr[9] && sd_addr[3] && sd_addr[2:0] == 3'b010)); // R6
    AST_NORM_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        norm_req |-> sel_none); // R7
    AST_DELAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        delay_done |=> delay_done); // R8
    AST_DONE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_ok) |-> delay_done); // R9

endmodule

bind sdram_init_cmdgen sdram_init_cmdgen_chk #(
    .CS_N (CS_N)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .norm_req   (norm_req),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .delay_done (delay_done),
    .init_ok    (init_ok)
);

// File: tb/test_sdram_init_cmdgen.sv
module test_sdram_init_cmdgen;

    localparam int CLK_PERIOD = 10;
    localparam int HADDR_W    = 24;
    localparam int CS_N       = 4;
    localparam int REC_CYC    = 3;
    localparam int DELAY_CYC  = 40;
    localparam int WDOG_CYC   = 20000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         op_mode = 3'b000;
    logic               cas_lat3 = 1'b0;
    logic               host_req = 1'b0;
    logic               host_we = 1'b0;
    logic [HADDR_W-1:0] host_addr = '0;
    logic               host_ack;
    logic               norm_req;
    logic               norm_we;
    logic [HADDR_W-1:0] norm_addr;
    logic [CS_N-1:0]    sd_cs_n;
    logic               sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0]        sd_addr;
    logic               delay_done;
    logic               init_ok;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sdram_init_cmdgen #(
        .HADDR_W   (HADDR_W),
        .CS_N      (CS_N),
        .REC_CYC   (REC_CYC),
        .DELAY_CYC (DELAY_CYC)
    ) i_sdram_init_cmdgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_mode    (op_mode),
        .cas_lat3   (cas_lat3),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_ack   (host_ack),
        .norm_req   (norm_req),
        .norm_we    (norm_we),
        .norm_addr  (norm_addr),
        .sd_cs_n    (sd_cs_n),
        .sd_ras_n   (sd_ras_n),
        .sd_cas_n   (sd_cas_n),
        .sd_we_n    (sd_we_n),
        .sd_addr    (sd_addr),
        .delay_done (delay_done),
        .init_ok    (init_ok)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [6:0] pins_now();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    function automatic logic [6:0] pins_exp(input logic [3:0] p);
        return {{CS_N{p[3]}}, p[2:0]};
    endfunction

    // one special-mode access: command cycle, then recovery until acknowledge
    task automatic run_access(input logic [2:0] op, input logic cl,
                              input logic [3:0] exp_pins, input logic [12:0] exp_addr,
                              input string tag);
        int n;
        @(negedge clk);
        op_mode   = op;
        cas_lat3  = cl;
        host_we   = 1'b0;
        host_addr = 24'h00ABCD;
        host_req  = 1'b1;
        @(negedge clk);
        chk(pins_now() == pins_exp(exp_pins), tag, "command pins", 32'(pins_now()), 32'(pins_exp(exp_pins)));
        chk(sd_addr == exp_addr, tag, "command address", 32'(sd_addr), 32'(exp_addr));
        chk(!host_ack && !norm_req, "R2", "no ack during command", 32'({host_ack, norm_req}), 32'h0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            chk(pins_now() == 7'h7F && sd_addr == '0, "R2", "deselect in recovery",
                32'(pins_now()), 32'h7F);
        end while (!host_ack && n < 20);
        chk(n == REC_CYC, "R2", "recovery cycles to ack", 32'(n), 32'(REC_CYC));
        host_req = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pins_now() == 7'h7F && sd_addr == '0, "R1", "pins in reset", 32'(pins_now()), 32'h7F);
        chk({host_ack, norm_req, delay_done, init_ok} == 4'b0, "R1", "flags in reset",
            32'({host_ack, norm_req, delay_done, init_ok}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pins_now() == 7'h7F && sd_addr == '0, "R1", "pins after reset", 32'(pins_now()), 32'h7F);
        chk({host_ack, norm_req, delay_done, init_ok} == 4'b0, "R1", "flags after reset",
            32'({host_ack, norm_req, delay_done, init_ok}), 32'h0);
    endtask

    task automatic t_early_steps();
        run_access(3'b001, 1'b0, 4'b0111, 13'h0000, "R3");
        chk(init_ok == 1'b0, "R9", "no status after NOP", 32'(init_ok), 32'h0);
        run_access(3'b010, 1'b0, 4'b0010, 13'h0400, "R4");
        chk(init_ok == 1'b0, "R10", "precharge before delay", 32'(init_ok), 32'h0);
        chk(delay_done == 1'b0, "R8", "delay still running", 32'(delay_done), 32'h0);
    endtask

    task automatic t_delay();
        int guard = 0;
        while (cyc < DELAY_CYC - 1 && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk(delay_done == 1'b0, "R8", "one edge before limit", 32'(delay_done), 32'h0);
        @(negedge clk);
        chk(delay_done == 1'b1, "R8", "at limit", 32'(delay_done), 32'h1);
        repeat (5) @(negedge clk);
        chk(delay_done == 1'b1, "R8", "stays high", 32'(delay_done), 32'h1);
    endtask

    task automatic t_full_sequence();
        run_access(3'b001, 1'b0, 4'b0111, 13'h0000, "R3");
        run_access(3'b010, 1'b0, 4'b0010, 13'h0400, "R4");
        run_access(3'b100, 1'b0, 4'b0001, 13'h0000, "R5");
        run_access(3'b100, 1'b0, 4'b0001, 13'h0000, "R5");
        chk(init_ok == 1'b0, "R9", "not yet before load", 32'(init_ok), 32'h0);
        run_access(3'b011, 1'b0, 4'b0000, 13'h022A, "R6");
        chk(init_ok == 1'b1, "R9", "status after full order", 32'(init_ok), 32'h1);
    endtask

    task automatic t_normal();
        @(negedge clk);
        op_mode   = 3'b000;
        host_we   = 1'b1;
        host_addr = 24'h5A3C71;
        host_req  = 1'b1;
        @(negedge clk);
        chk(norm_req && host_ack, "R7", "pass strobe and ack", 32'({norm_req, host_ack}), 32'h3);
        chk(norm_we == 1'b1 && norm_addr == 24'h5A3C71, "R7", "pass address", 32'(norm_addr), 32'h5A3C71);
        chk(pins_now() == 7'h7F, "R7", "no command", 32'(pins_now()), 32'h7F);
        host_req = 1'b0;
        @(negedge clk);
        chk(!norm_req && !host_ack, "R7", "single cycle", 32'({norm_req, host_ack}), 32'h0);
        chk(init_ok == 1'b1, "R9", "kept through normal access", 32'(init_ok), 32'h1);
    endtask

    task automatic t_unused_codes();
        for (int c = 5; c < 8; c++) begin
            run_access(3'(c), 1'b0, 4'b0111, 13'h0000, "R3");
        end
        chk(init_ok == 1'b1, "R9", "kept through NOPs", 32'(init_ok), 32'h1);
    endtask

    task automatic t_out_of_order();
        run_access(3'b100, 1'b0, 4'b0001, 13'h0000, "R5");
        chk(init_ok == 1'b0, "R10", "refresh after done", 32'(init_ok), 32'h0);
        run_access(3'b011, 1'b1, 4'b0000, 13'h023A, "R6");
        chk(init_ok == 1'b0, "R10", "load out of order", 32'(init_ok), 32'h0);
        run_access(3'b001, 1'b0, 4'b0111, 13'h0000, "R3");
        run_access(3'b010, 1'b0, 4'b0010, 13'h0400, "R4");
        run_access(3'b100, 1'b0, 4'b0001, 13'h0000, "R5");
        run_access(3'b011, 1'b0, 4'b0000, 13'h022A, "R6");
        chk(init_ok == 1'b0, "R10", "load after one refresh", 32'(init_ok), 32'h0);
    endtask

    task automatic t_long_refresh();
        run_access(3'b001, 1'b0, 4'b0111, 13'h0000, "R3");
        run_access(3'b010, 1'b1, 4'b0010, 13'h0400, "R4");
        run_access(3'b010, 1'b1, 4'b0010, 13'h0400, "R4");
        for (int i = 0; i < 3; i++) begin
            run_access(3'b100, 1'b1, 4'b0001, 13'h0000, "R5");
        end
        run_access(3'b011, 1'b1, 4'b0000, 13'h023A, "R6");
        chk(init_ok == 1'b1, "R9", "status after three refreshes", 32'(init_ok), 32'h1);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG_CYC, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_early_steps();
        t_delay();
        t_full_sequence();
        t_normal();
        t_unused_codes();
        t_out_of_order();
        t_long_refresh();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule